// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit timer/counter and a watchdog counter. A single 8-bit prescaler is lent to exactly one of the two. A six-bit mode register selects four things:

- the timer's clock source, which is either the instruction-cycle strobe or an external pin;
- which edge of that pin counts;
- which counter owns the prescaler;
- a three-bit division ratio.

The external pin passes through a two-stage synchroniser before its edges are detected. The watchdog's time base is a tick input supplied by the surrounding logic.

Software loads the timer through a plain write port. It restarts the watchdog with a clear strobe. When the watchdog reaches its limit, it emits a one-cycle timeout pulse and drops a timeout status flag. The flag stays low until the next clear. There is no streaming data path here: every pin is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `tw_timer_wdt`

## Requirements
- R1: With mode bit 5 = 0 and the prescaler owned by the watchdog, the timer advances by exactly one on each cycle in which `cyc_stb` is high, and `cyc_stb` has no effect when mode bit 5 = 1.
- R2: With mode bit 5 = 1, a change on `ext_clk` driven before clock edge e0 reaches `tmr_q` after edge e2: two synchroniser stages, then the counter.
- R3: Mode bit 4 = 0 counts rising edges of `ext_clk`; mode bit 4 = 1 counts falling edges. The other edge leaves the timer unchanged.
- R4: With mode bit 3 = 0 the prescaler belongs to the timer, and the timer advances once per 2^(PS+1) source events, where PS is mode bits 2:0 (1:2 up to 1:256).
- R5: With mode bit 3 = 1 the watchdog advances once per 2^PS ticks of `wdt_tick` (1:1 up to 1:128). With mode bit 3 = 0 it advances on every tick.
- R6: `tmr_we` loads `tmr_wdata` into the timer on the next edge, overriding any count. While the prescaler belongs to the timer, the same write also clears the prescaler.
- R7: `clr_wdt` zeroes the watchdog count. It also clears the prescaler when mode bit 3 = 1.
- R8: The WDT_LIMIT-th watchdog advance after a clear raises `wdt_timeout` for exactly one cycle and drives `to_flag` low. `clr_wdt` sets `to_flag` back to 1.
- R9: While `wdt_en` is 0 the watchdog count is held at zero and no timeout occurs.
- R10: The timer wraps from 0xFF to 0x00.
- R11: After reset, `tmr_q` = 0, `wdt_timeout` = 0, `to_flag` = 1, and the mode register holds 0x3F (external falling edge, prescaler on watchdog, ratio 7).
- R12: A mode write with `mode_we` takes effect from the cycle after the write. Events in the write cycle use the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | Instruction-cycle strobe, the internal count source |
| ext_clk | input | 1 | External count pin (asynchronous) |
| wdt_tick | input | 1 | Watchdog time-base tick |
| wdt_en | input | 1 | Watchdog enable |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode value: [5] source, [4] edge, [3] assign, [2:0] ratio |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer load value |
| clr_wdt | input | 1 | Clear-watchdog command |
| tmr_q | output | 8 | Current timer value |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |
| to_flag | output | 1 | Timeout status, low after a timeout until cleared |

## Verification
The timer is driven by bursts of instruction strobes under each prescaler ratio. Each burst length is chosen to be one short of a prescaler rollover, exactly on one, or a multiple of one, so that an off-by-one in the ratio tap or the ownership mux shows as a wrong count. The external pin is toggled in both directions under both edge selections, and the result is sampled one edge before and on the edge where the synchronised edge should land, which pins down the latency. On the watchdog side, tick bursts of length limit-minus-one and limit are applied after a clear, with and without the prescaler. A partial prescaler count is left before the clear, which exposes a prescaler that the clear failed to reset.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PS_W = 3;

  typedef struct packed {
    logic            src_ext;   // 1: external pin, 0: instruction strobe
    logic            edge_fall; // 1: falling edges, 0: rising edges
    logic            pre_wdt;   // 1: prescaler on watchdog, 0: on timer
    logic [PS_W-1:0] ratio;
  } tw_mode_t;

  localparam int MODE_W = PS_W + 3;
  localparam tw_mode_t MODE_RST = '1;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [STAGES:0] sh;
  logic            cur, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign cur  = sh[STAGES-1];
  assign prev = sh[STAGES];
  assign evt  = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  input  logic [PS_W-1:0] ratio,
  input  logic            own_tmr,
  output logic            tap
);
  localparam int PRE_W = 1 << PS_W;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;
  logic [PS_W:0]    span;

  // Timer ownership divides by 2^(ratio+1), watchdog by 2^ratio.
  assign span = {1'b0, ratio} + (PS_W+1)'(own_tmr);

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (PS_W+1)'(i) < span;
  end

  assign tap = inc & ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_counter.sv
module tw_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         adv,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (we)  q <= wdata;
    else if (adv) q <= q + 1'b1;
  end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic adv,
  output logic timeout,
  output logic to_flag
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = en & ~clr & adv & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
      to_flag <= 1'b1;
    end else begin
      timeout <= expire;
      if (!en || clr)  cnt <= '0;
      else if (expire) cnt <= '0;
      else if (adv)    cnt <= cnt + 1'b1;
      if (clr)         to_flag <= 1'b1;
      else if (expire) to_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_timer_wdt.sv
module tw_timer_wdt
  import tw_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int WDT_LIMIT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              ext_clk,
  input  logic              wdt_tick,
  input  logic              wdt_en,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              tmr_we,
  input  logic [TMR_W-1:0]  tmr_wdata,
  input  logic              clr_wdt,
  output logic [TMR_W-1:0]  tmr_q,
  output logic              wdt_timeout,
  output logic              to_flag
);
  tw_mode_t mode_q;
  logic     ext_evt, tmr_src, pre_inc, pre_clr, pre_tap, tmr_adv, wdt_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_we) mode_q <= tw_mode_t'(mode_wdata);
  end

  tw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk),
    .fall_sel(mode_q.edge_fall), .evt(ext_evt)
  );

  assign tmr_src = mode_q.src_ext ? ext_evt : cyc_stb;
  assign pre_inc = mode_q.pre_wdt ? wdt_tick : tmr_src;
  assign pre_clr = mode_q.pre_wdt ? clr_wdt : tmr_we;
  assign tmr_adv = mode_q.pre_wdt ? tmr_src : pre_tap;
  assign wdt_adv = mode_q.pre_wdt ? pre_tap : wdt_tick;

  tw_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .inc(pre_inc),
    .ratio(mode_q.ratio), .own_tmr(~mode_q.pre_wdt), .tap(pre_tap)
  );

  tw_counter #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .we(tmr_we), .wdata(tmr_wdata),
    .adv(tmr_adv), .q(tmr_q)
  );

  tw_watchdog #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .clr(clr_wdt),
    .adv(wdt_adv), .timeout(wdt_timeout), .to_flag(to_flag)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker
  import tw_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_stb,
  input logic             wdt_en,
  input logic             tmr_we,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic             clr_wdt,
  input logic [TMR_W-1:0] tmr_q,
  input logic             wdt_timeout,
  input logic             to_flag,
  input tw_mode_t         mode_q
);
  AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.src_ext && mode_q.pre_wdt && !tmr_we && cyc_stb) |=> tmr_q == TMR_W'($past(tmr_q) + 1'b1)); // R1
  AST_INT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.src_ext && mode_q.pre_wdt && !tmr_we && !cyc_stb) |=> $stable(tmr_q)); // R1
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> tmr_q == $past(tmr_wdata)); // R6
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> (tmr_q == $past(tmr_q) || tmr_q == TMR_W'($past(tmr_q) + 1'b1))); // R10
  AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout); // R8
  AST_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> !to_flag); // R8
  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> (!wdt_timeout && to_flag)); // R7
  AST_WDT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_timeout); // R9
endmodule

bind tw_timer_wdt tw_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .wdt_en(wdt_en),
  .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .clr_wdt(clr_wdt),
  .tmr_q(tmr_q), .wdt_timeout(wdt_timeout), .to_flag(to_flag),
  .mode_q(mode_q)
);

// File: tb/tb_tw_timer_wdt.sv
`timescale 1ns/1ps
module tb_tw_timer_wdt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 0, ext_clk = 0, wdt_tick = 0, wdt_en = 0;
  logic       mode_we = 0, tmr_we = 0, clr_wdt = 0;
  logic [5:0] mode_wdata = '0;
  logic [7:0] tmr_wdata = '0;
  logic [7:0] tmr_q;
  logic       wdt_timeout, to_flag;
  int         nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  tw_timer_wdt dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext_clk(ext_clk),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
    .clr_wdt(clr_wdt), .tmr_q(tmr_q), .wdt_timeout(wdt_timeout),
    .to_flag(to_flag)
  );

  // mode[31:24], strobe count[23:8], expected timer[7:0]
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h08, 16'd5,   8'd5},  // R1 direct
    {8'h00, 16'd5,   8'd2},  // R4 1:2
    {8'h01, 16'd9,   8'd2},  // R4 1:4
    {8'h02, 16'd16,  8'd2},  // R4 1:8
    {8'h03, 16'd47,  8'd2},  // R4 1:16
    {8'h07, 16'd255, 8'd0},  // R4 1:256 short
    {8'h07, 16'd256, 8'd1},  // R4 1:256 exact
    {8'h0F, 16'd3,   8'd3}   // R1 ratio ignored
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(logic [5:0] m);
    mode_wdata = m; mode_we = 1; step(1); mode_we = 0;
  endtask

  task automatic wr_tmr(logic [7:0] v);
    tmr_wdata = v; tmr_we = 1; step(1); tmr_we = 0;
  endtask

  task automatic strobes(int n);
    cyc_stb = 1; step(n); cyc_stb = 0;
  endtask

  task automatic ticks(int n);
    wdt_tick = 1; step(n); wdt_tick = 0;
  endtask

  task automatic clear_wdt();
    clr_wdt = 1; step(1); clr_wdt = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    // R11 reset state
    check("R11 tmr", tmr_q, 0);
    check("R11 to_flag", to_flag, 1);
    check("R11 timeout", wdt_timeout, 0);
    strobes(3);
    check("R11 reset mode is external", tmr_q, 0);

    for (int i = 0; i < NV; i++) begin
      wr_mode(VEC[i][29:24]);
      wr_tmr(8'h00);
      strobes(int'(VEC[i][23:8]));
      check($sformatf("R4/R1 vector %0d", i), tmr_q, VEC[i][7:0]);
    end

    // R10 wrap
    wr_mode(6'h08);
    wr_tmr(8'hFE);
    strobes(2);
    check("R10 wrap", tmr_q, 8'h00);

    // R6 load and prescaler clear
    wr_tmr(8'h5A);
    check("R6 load", tmr_q, 8'h5A);
    wr_mode(6'h01);
    wr_tmr(8'h00);
    strobes(3);
    wr_tmr(8'h00);
    strobes(3);
    check("R6 prescaler cleared", tmr_q, 0);
    strobes(1);
    check("R6 first rollover", tmr_q, 1);

    // R2 / R3 external rising
    wr_mode(6'h28);
    wr_tmr(8'h00);
    ext_clk = 1;
    step(2);
    check("R2 not yet", tmr_q, 0);
    step(1);
    check("R2 latency", tmr_q, 1);
    ext_clk = 0;
    step(4);
    check("R3 falling ignored", tmr_q, 1);
    strobes(2);
    check("R1 strobe ignored external", tmr_q, 1);
    // R3 falling
    wr_mode(6'h38);
    ext_clk = 1;
    step(4);
    check("R3 rising ignored", tmr_q, 1);
    ext_clk = 0;
    step(3);
    check("R3 falling counted", tmr_q, 2);

    // R12 mode write timing
    mode_wdata = 6'h08; mode_we = 1; cyc_stb = 1;
    step(1);
    mode_we = 0; cyc_stb = 0;
    check("R12 old mode in write cycle", tmr_q, 2);
    strobes(1);
    check("R12 new mode next cycle", tmr_q, 3);

    // R5 / R7 / R8 watchdog with prescaler 1:4
    wr_mode(6'h0A);
    wdt_en = 1;
    clear_wdt();
    ticks(2);
    clear_wdt();
    ticks(63);
    check("R7 clear restarts prescaler", to_flag, 1);
    check("R5 no early timeout", wdt_timeout, 0);
    ticks(1);
    check("R8 timeout pulse", wdt_timeout, 1);
    check("R8 to_flag low", to_flag, 0);
    step(1);
    check("R8 single cycle", wdt_timeout, 0);
    clear_wdt();
    check("R8 clear sets flag", to_flag, 1);

    // R5 direct ticks
    wr_mode(6'h00);
    clear_wdt();
    ticks(15);
    check("R5 direct short", to_flag, 1);
    ticks(1);
    check("R5 direct timeout", wdt_timeout, 1);

    // R9 disabled
    clear_wdt();
    wdt_en = 0;
    ticks(40);
    check("R9 disabled flag", to_flag, 1);
    check("R9 disabled pulse", wdt_timeout, 0);
    wdt_en = 1;
    ticks(15);
    check("R9 held at zero", to_flag, 1);
    ticks(1);
    check("R9 enabled timeout", wdt_timeout, 1);

    step(2);
    finish_run();
  end
endmodule